// File: doc/BRIEF.md
# Predictive Coding Neuron Core

This block is one scalar neuron of a layered predictive-coding network. On each start pulse it runs a single local update tick. The tick forms a prediction of its own value from the states of the layer above, then the prediction error. It gathers the error products sent up from the layer below and hands its own weight-times-error products to the layer above. It then adjusts its weights with a Hebbian step and moves its state one Euler step. The tick ends with a one-cycle done pulse. The multiplications of a tick go one at a time through a single shared multiplier, so the length of a tick grows linearly with fan-in.

Values are signed fixed-point with `FRAC` fraction bits. With the defaults, `DW`=16 and `FRAC`=8, this is Q8.8. The activation applied to upper-layer inputs is set by a parameter: identity or a rectifier. A per-neuron observation enable replaces the stored state with an external value during the tick. When `HARD_CLAMP` is set, the enable also writes that value into the state at the end of the tick. Training clamps the input and output layers. Inference clamps only the input layer and sets the weight step `alpha` to zero.

The controller has the states IDLE, PRED, ERR, BSUM, BVEC, WUP and UPD. The transitions are:
- IDLE to PRED on start.
- PRED to ERR after N+1 cycles.
- ERR to BSUM after one cycle.
- BSUM to BVEC after M cycles.
- BVEC to WUP after N cycles.
- WUP to UPD after N+1 cycles.
- UPD to IDLE after one cycle, raising done.

Top module: `pc_neuron_core`

## Requirements
- R1: A start sampled in IDLE runs the stages PRED, ERR, BSUM, BVEC, WUP, UPD in that fixed order. The controller then returns to IDLE and raises `done` for exactly one cycle.
- R2: `done` is high in the cycle that follows the 3N+M+4 busy cycles after the clock edge that samples start.
- R3: PRED forms mu = sum over j<N of theta_j*f(x_j), plus the bias weight theta_N times the constant feature 1.0. Input x_j is the slice `up_x[j*DW +: DW]`.
- R4: Values are two's-complement with FRAC fraction bits. A product is shifted right arithmetically by FRAC bits (truncation) and saturated to the DW-bit range. Each sum or difference saturates at the same limits.
- R5: During BVEC, `bv_valid` is high for exactly N consecutive cycles. In those cycles `bv_index` counts 0..N-1 and `bv_data` = theta_j*eps, using the weights from before this tick's weight update.
- R6: WUP sets theta_j += (alpha*eps)*f(x_j) for j<N and theta_N += alpha*eps. When alpha is 0 the stage still runs and every weight is unchanged.
- R7: ERR stores eps = x_eff - mu. x_eff is `obs_x` when `obs_en` is high and the stored state otherwise.
- R8: UPD sets x += gamma*(f'(x_eff)*b - eps). If HARD_CLAMP is 1 and `obs_en` is high, the state is instead set to `obs_x`.
- R9: With ACT_RELU=1, f(v)=v for v>0 and 0 otherwise, and f'(v) is 1.0 for v>0 and 0 otherwise. With ACT_RELU=0, f is identity and f' is 1.0.
- R10: A start pulse that arrives while a tick is running, including in its UPD cycle, is ignored. It neither lengthens the tick nor causes another one.
- R11: After reset, the state and error are 0, every weight equals W_INIT, and `done` and `bv_valid` are low.
- R12: BSUM forms b as the saturating sum of the M lower-layer products, with product k being `dn_prod[k*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Tick request, taken only in IDLE |
| up_x | input | N*DW | Raw states of the upper-layer neurons |
| dn_prod | input | M*DW | Error-weighted products from the lower layer |
| obs_x | input | DW | Observation value |
| obs_en | input | 1 | Observation clamp enable for this tick |
| alpha | input | DW | Weight step size |
| gamma | input | DW | State step size |
| state_x | output | DW | Stored state, sent downward |
| bv_valid | output | 1 | Backward product valid |
| bv_index | output | IW | Index of the backward product |
| bv_data | output | DW | Weight-times-error product, sent upward |
| done | output | 1 | One-cycle end-of-tick pulse |

## Verification
A request for the next tick can meet the end of the current one, and the core must tell two such coincidences apart. The bench raises start during the UPD cycle, where it must be dropped, as it also is when raised in the middle of PRED. Both cases are judged by an unchanged tick length and by the absence of a further done pulse. The bench also raises start in the very cycle done is shown. This is an IDLE cycle, so the request must begin a new tick immediately. That tick is checked in full against a reference model: its backward stream, its length and its final state.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRED,
        ST_ERR,
        ST_BSUM,
        ST_BVEC,
        ST_WUP,
        ST_UPD
    } pcn_stage_e;
endpackage

// File: rtl/pcn_mul.sv
module pcn_mul #(
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] p
);
    localparam int PW = 2 * DW;
    localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -PW'(64'sd1 <<< (DW - 1));

    logic signed [PW-1:0] full;
    logic signed [PW-1:0] shifted;

    always_comb begin
        full    = PW'(a) * PW'(b);
        shifted = full >>> FRAC;
        if (shifted > MAXV)      p = MAXV[DW-1:0];
        else if (shifted < MINV) p = MINV[DW-1:0];
        else                     p = shifted[DW-1:0];
    end
endmodule

// File: rtl/pcn_act.sv
module pcn_act #(
    parameter int DW       = 16,
    parameter int FRAC     = 8,
    parameter bit ACT_RELU = 1'b1
) (
    input  logic signed [DW-1:0] v,
    output logic signed [DW-1:0] fv,
    output logic                 dpos
);
    generate
        if (ACT_RELU) begin : g_relu
            always_comb begin
                dpos = (v > 0);
                fv   = dpos ? v : '0;
            end
        end else begin : g_ident
            always_comb begin
                dpos = 1'b1;
                fv   = v;
            end
        end
    endgenerate
endmodule

// File: rtl/pcn_ctrl.sv
module pcn_ctrl
    import pcn_pkg::*;
#(
    parameter int N  = 3,
    parameter int M  = 2,
    parameter int CW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output pcn_stage_e       stage,
    output logic [CW-1:0]    cnt,
    output logic             done
);
    localparam logic [CW-1:0] LAST_NB = CW'(N);
    localparam logic [CW-1:0] LAST_N  = CW'(N - 1);
    localparam logic [CW-1:0] LAST_M  = CW'(M - 1);

    pcn_stage_e stage_nxt;
    logic       last;

    always_comb begin
        unique case (stage)
            ST_PRED: last = (cnt == LAST_NB);
            ST_WUP:  last = (cnt == LAST_NB);
            ST_BSUM: last = (cnt == LAST_M);
            ST_BVEC: last = (cnt == LAST_N);
            default: last = 1'b1;
        endcase
    end

    always_comb begin
        stage_nxt = stage;
        unique case (stage)
            ST_IDLE: if (start) stage_nxt = ST_PRED;
            ST_PRED: if (last)  stage_nxt = ST_ERR;
            ST_ERR:             stage_nxt = ST_BSUM;
            ST_BSUM: if (last)  stage_nxt = ST_BVEC;
            ST_BVEC: if (last)  stage_nxt = ST_WUP;
            ST_WUP:  if (last)  stage_nxt = ST_UPD;
            ST_UPD:             stage_nxt = ST_IDLE;
            default:            stage_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= ST_IDLE;
        end else begin
            stage <= stage_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            cnt  <= (stage_nxt != stage) ? '0 : (stage == ST_IDLE ? '0 : cnt + 1'b1);
            done <= (stage == ST_UPD);
        end
    end

    // R1: done lasts one cycle and comes only right after the update stage
    assert_done_after_upd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(stage) == ST_UPD && stage == ST_IDLE));
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: a busy core never falls back to IDLE before its update stage
    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != ST_IDLE && stage != ST_UPD) |=> stage != ST_IDLE);
    // R1: error stage is always followed by the back-sum stage
    assert_err_then_bsum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_ERR) |=> (stage == ST_BSUM && cnt == '0));
endmodule

// File: rtl/pc_neuron_core.sv
module pc_neuron_core
    import pcn_pkg::*;
#(
    parameter int                 N          = 3,
    parameter int                 M          = 2,
    parameter int                 DW         = 16,
    parameter int                 FRAC       = 8,
    parameter bit                 ACT_RELU   = 1'b1,
    parameter bit                 HARD_CLAMP = 1'b1,
    parameter logic signed [15:0] W_INIT     = 16'sh0080,
    parameter int                 IW         = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N*DW-1:0]      up_x,
    input  logic [M*DW-1:0]      dn_prod,
    input  logic signed [DW-1:0] obs_x,
    input  logic                 obs_en,
    input  logic signed [DW-1:0] alpha,
    input  logic signed [DW-1:0] gamma,
    output logic signed [DW-1:0] state_x,
    output logic                 bv_valid,
    output logic [IW-1:0]        bv_index,
    output logic signed [DW-1:0] bv_data,
    output logic                 done
);
    localparam int MAXNM = (N > M) ? N : M;
    localparam int CW    = $clog2(MAXNM + 1);
    localparam logic signed [DW-1:0] ONE  = DW'(1 << FRAC);
    localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] WINI = DW'(W_INIT);

    function automatic logic signed [DW-1:0] sat_add(input logic signed [DW-1:0] a,
                                                     input logic signed [DW-1:0] b);
        logic signed [DW:0] s;
        s = {a[DW-1], a} + {b[DW-1], b};
        if (s[DW] != s[DW-1]) return s[DW] ? SMIN : SMAX;
        return s[DW-1:0];
    endfunction

    function automatic logic signed [DW-1:0] sat_sub(input logic signed [DW-1:0] a,
                                                     input logic signed [DW-1:0] b);
        logic signed [DW:0] s;
        s = {a[DW-1], a} - {b[DW-1], b};
        if (s[DW] != s[DW-1]) return s[DW] ? SMIN : SMAX;
        return s[DW-1:0];
    endfunction

    pcn_stage_e      stage;
    logic [CW-1:0]   cnt;

    logic signed [DW-1:0] theta [0:N];
    logic [(N+1)*DW-1:0]  theta_flat;
    logic signed [DW-1:0] x_q, eps_q, mu_q, b_q;

    logic signed [DW-1:0] up_sel, dn_sel, th_sel, f_up, x_eff, g_term;
    logic                 up_pos_unused, d_eff;
    logic signed [DW-1:0] f_eff_unused;
    logic signed [DW-1:0] mac_a, mac_b, mac_p, ae;
    logic                 is_bias;

    pcn_ctrl #(.N(N), .M(M), .CW(CW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .stage (stage),
        .cnt   (cnt),
        .done  (done)
    );

    // operand selection by running index
    always_comb begin
        up_sel = '0;
        dn_sel = '0;
        th_sel = theta[N];
        for (int j = 0; j < N; j++) begin
            if (cnt == CW'(j)) begin
                up_sel = up_x[j*DW +: DW];
                th_sel = theta[j];
            end
        end
        for (int k = 0; k < M; k++) begin
            if (cnt == CW'(k)) dn_sel = dn_prod[k*DW +: DW];
        end
    end

    assign is_bias = (cnt == CW'(N));
    assign x_eff   = obs_en ? obs_x : x_q;

    pcn_act #(.DW(DW), .FRAC(FRAC), .ACT_RELU(ACT_RELU)) u_act_up (
        .v    (up_sel),
        .fv   (f_up),
        .dpos (up_pos_unused)
    );

    pcn_act #(.DW(DW), .FRAC(FRAC), .ACT_RELU(ACT_RELU)) u_act_eff (
        .v    (x_eff),
        .fv   (f_eff_unused),
        .dpos (d_eff)
    );

    assign g_term = sat_sub(d_eff ? b_q : '0, eps_q);

    // shared multiplier operand steering
    always_comb begin
        mac_a = '0;
        mac_b = '0;
        unique case (stage)
            ST_PRED: begin mac_a = th_sel; mac_b = is_bias ? ONE : f_up; end
            ST_BVEC: begin mac_a = th_sel; mac_b = eps_q; end
            ST_WUP:  begin mac_a = ae;     mac_b = is_bias ? ONE : f_up; end
            ST_UPD:  begin mac_a = gamma;  mac_b = g_term; end
            default: begin mac_a = '0;     mac_b = '0; end
        endcase
    end

    pcn_mul #(.DW(DW), .FRAC(FRAC)) u_mac (.a(mac_a), .b(mac_b), .p(mac_p));
    pcn_mul #(.DW(DW), .FRAC(FRAC)) u_step (.a(alpha), .b(eps_q), .p(ae));

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            eps_q <= '0;
            mu_q  <= '0;
            b_q   <= '0;
            for (int j = 0; j <= N; j++) theta[j] <= WINI;
        end else begin
            unique case (stage)
                ST_IDLE: begin
                    mu_q <= '0;
                    b_q  <= '0;
                end
                ST_PRED: mu_q  <= sat_add(mu_q, mac_p);
                ST_ERR:  eps_q <= sat_sub(x_eff, mu_q);
                ST_BSUM: b_q   <= sat_add(b_q, dn_sel);
                ST_WUP: begin
                    for (int j = 0; j <= N; j++) begin
                        if (cnt == CW'(j)) theta[j] <= sat_add(theta[j], mac_p);
                    end
                end
                ST_UPD: x_q <= (HARD_CLAMP && obs_en) ? obs_x : sat_add(x_q, mac_p);
                default: ;
            endcase
        end
    end

    genvar gj;
    generate
        for (gj = 0; gj <= N; gj++) begin : g_flat
            assign theta_flat[gj*DW +: DW] = theta[gj];
        end
    endgenerate

    assign state_x  = x_q;
    assign bv_valid = (stage == ST_BVEC);
    assign bv_index = IW'(cnt);
    assign bv_data  = bv_valid ? mac_p : '0;

    // R6: a zero weight step leaves every weight untouched through WUP
    assert_alpha_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_WUP && alpha == '0) |=> $stable(theta_flat));
    // R6: weights only move in the weight-update stage
    assert_weights_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != ST_WUP) |=> $stable(theta_flat));
    // R8: hard clamp leaves the observation in the state register
    assert_hard_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (HARD_CLAMP && stage == ST_UPD && obs_en) |=> (x_q == $past(obs_x)));
    // R8: state changes only at the end of a tick
    assert_state_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != ST_UPD) |=> $stable(x_q));
    // R5: backward index stays inside the non-bias lanes
    assert_bv_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bv_valid |-> (int'(bv_index) < N));
endmodule

// File: tb/pc_neuron_core_test.sv
module pc_neuron_core_test;
    localparam int N = 3;
    localparam int M = 2;
    localparam int DW = 16;
    localparam int TICK = 3*N + M + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*DW-1:0] up_x = '0;
    logic [M*DW-1:0] dn_prod = '0;
    logic signed [DW-1:0] obs_x = '0, alpha = '0, gamma = '0;
    logic obs_en = 1'b0;
    logic signed [DW-1:0] state_x, bv_data;
    logic bv_valid, done;
    logic [1:0] bv_index;

    always #4 clk = ~clk;

    pc_neuron_core uut (
        .clk(clk), .rst_n(rst_n), .start(start), .up_x(up_x), .dn_prod(dn_prod),
        .obs_x(obs_x), .obs_en(obs_en), .alpha(alpha), .gamma(gamma),
        .state_x(state_x), .bv_valid(bv_valid), .bv_index(bv_index),
        .bv_data(bv_data), .done(done)
    );

    int checks = 0, errors = 0;
    int q_idx[$], q_dat[$];
    int m_th[N+1];
    int m_x;

    function automatic int sat(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction
    function automatic int smul(int a, int b);
        longint p = longint'(a) * longint'(b);
        return sat(p >>> 8);
    endfunction
    function automatic int fr(int v);
        return (v > 0) ? v : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor for the backward stream (R5)
    always @(negedge clk) begin
        if (rst_n && bv_valid) begin
            if (q_idx.size() == 0) begin
                chk("R5 unexpected product", 1, 0);
            end else begin
                chk("R5 index", int'(bv_index), q_idx.pop_front());
                chk("R5 data", int'(bv_data), q_dat.pop_front());
            end
        end
    end

    // driver: model the tick, queue expectations, run it, check length and state
    task automatic run_tick(int u0, int u1, int u2, int d0, int d1, int ob, bit en,
                            int al, int ga, int mid_start, bit late_start);
        int u[N]; int d[M];
        int mu, xe, eps, b, ae, g, n;
        u[0] = u0; u[1] = u1; u[2] = u2; d[0] = d0; d[1] = d1;
        mu = 0;
        for (int j = 0; j < N; j++) mu = sat(longint'(mu) + smul(m_th[j], fr(u[j])));  // R3 R9
        mu = sat(longint'(mu) + m_th[N]);
        xe = en ? ob : m_x;                                                         // R7
        eps = sat(longint'(xe) - mu);
        b = 0;
        for (int k = 0; k < M; k++) b = sat(longint'(b) + d[k]);                    // R12
        for (int j = 0; j < N; j++) begin q_idx.push_back(j); q_dat.push_back(smul(m_th[j], eps)); end
        ae = smul(al, eps);                                                         // R6
        for (int j = 0; j < N; j++) m_th[j] = sat(longint'(m_th[j]) + smul(ae, fr(u[j])));
        m_th[N] = sat(longint'(m_th[N]) + ae);
        g = sat(longint'((xe > 0) ? b : 0) - eps);                                  // R8
        m_x = en ? ob : sat(longint'(m_x) + smul(ga, g));

        up_x = {u2[15:0], u1[15:0], u0[15:0]};
        dn_prod = {d1[15:0], d0[15:0]};
        obs_x = ob[15:0]; obs_en = en; alpha = al[15:0]; gamma = ga[15:0];
        start = 1'b1;
        n = 0;
        while (n < TICK + 20) begin
            @(negedge clk);
            n++;
            start = (n == mid_start) || (late_start && n == TICK);
            if (done) break;
        end
        start = 1'b0;
        chk("R2 tick length", n, TICK + 1);
        chk("R8 state", int'(state_x), m_x);
        chk("R5 stream drained", q_idx.size(), 0);
        q_idx.delete(); q_dat.delete();
    endtask

    task automatic no_done(string req, int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk(req, seen, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int j = 0; j <= N; j++) m_th[j] = 128;
        m_x = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 state", int'(state_x), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 bv_valid", int'(bv_valid), 0);

        // R3 R7 R8 free-running tick, mixed-sign inputs, R9 negative input gated
        run_tick(256, -128, 512, 64, 128, 0, 1'b0, 32, 64, 0, 1'b0);
        // R7 R8 hard clamp with observation, R6 alpha 0
        run_tick(256, 256, 256, -64, 32, 384, 1'b1, 0, 64, 0, 1'b0);
        // R6 previous alpha 0: weights seen through this stream, R9 negative state gates b
        run_tick(128, 0, -256, 100, 100, -200, 1'b1, 16, 32, 0, 1'b0);
        // R10 start inside PRED is ignored
        run_tick(64, 64, 64, 0, 0, 0, 1'b0, 8, 16, 4, 1'b0);
        // R4 saturation of products and sums
        run_tick(25600, 25600, 25600, 30000, 30000, 0, 1'b0, 256, 256, 0, 1'b0);
        // R10 start during UPD ignored, then no further done
        run_tick(-300, 200, 100, -50, 20, 0, 1'b0, 4, 8, 0, 1'b1);
        no_done("R10 late start", TICK + 8);
        // R1 back-to-back: start in the done cycle begins a new tick
        run_tick(100, 200, 300, 10, 20, 0, 1'b0, 0, 16, 0, 1'b0);
        run_tick(50, -50, 150, -10, 5, 0, 1'b0, 64, 128, 0, 1'b0);
        no_done("R1 single done", 10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule